// File: doc/BRIEF.md
# Extended Feature-Control Register Write Guard

This block holds a 64-bit feature-control register and judges every attempt to write it through the privileged write operation. Each attempt carries an OS-enable flag, the current privilege level, a register-select index and a 64-bit value split into low and high halves. The block accepts the attempt only when it passes every consistency rule. Otherwise it leaves the register untouched and raises exactly one fault pulse: invalid-opcode or general-protection.

The register contents then gate two instruction classes. The wide-vector class needs bit 2 set. The bounds-checking class needs bits 4:3 both set. Both classes also need the OS-enable flag. A capability mask tells the block which register bits the implementation lets software set.

Top module: `ext_ctl_reg_guard`

## Requirements
- R1: When `os_en` is 0, a write attempt (`wr_req`) or a read attempt (`rd_req`) raises `ud_pulse`, and `ctl_q` stays unchanged.
- R2: When `os_en` is 1 and `priv_lvl` is not 0, a write attempt raises `gp_pulse`, and `ctl_q` stays unchanged.
- R3: An accepted write with `wr_sel` equal to 0 loads `wr_lo` into `ctl_q[31:0]` and `wr_hi` into `ctl_q[63:32]`. The new value is visible in the cycle after the strobe. A write attempt with a nonzero `wr_sel` raises `gp_pulse`, and `ctl_q` stays unchanged.
- R4: After reset, `ctl_q` is 64'h1. A write whose bit 0 is clear raises `gp_pulse`, and `ctl_q` stays unchanged.
- R5: A write whose bits 2:1 are binary 10 raises `gp_pulse`, and `ctl_q` stays unchanged.
- R6: The settable bits are those of `cap_mask` together with bits 1 and 0. A write that sets any other bit raises `gp_pulse`, and `ctl_q` stays unchanged. So bit 2 can be set only when `cap_mask[2]` is 1.
- R7: `vec_ok` is 1 exactly when `os_en` is 1 and `ctl_q[2]` is 1. The output is combinational.
- R8: `bnd_ok` is 1 exactly when `os_en` is 1 and `ctl_q[4:3]` is binary 11. The output is combinational.
- R9: The fault checks run in a fixed order: invalid-opcode first, then privilege level, then select index, then value. At most one fault pulse is raised per attempt. The pulse is high for exactly the one cycle after the strobe edge.
- R10: A read attempt with `os_en` equal to 1 raises no fault and does not change `ctl_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_en | input | 1 | OS-enable flag taken from the system control register |
| priv_lvl | input | 2 | Current privilege level; 0 is the most privileged |
| wr_sel | input | 32 | Register-select index of the write operation |
| wr_lo | input | 32 | Low half of the write value |
| wr_hi | input | 32 | High half of the write value |
| wr_req | input | 1 | Write attempt strobe |
| rd_req | input | 1 | Read attempt strobe |
| cap_mask | input | 64 | Bits the implementation allows software to set |
| ctl_q | output | 64 | Current register value |
| ud_pulse | output | 1 | Invalid-opcode fault pulse |
| gp_pulse | output | 1 | General-protection fault pulse |
| vec_ok | output | 1 | Wide-vector instruction class permitted |
| bnd_ok | output | 1 | Bounds-checking instruction class permitted |

## Verification
Some rules can be checked on every cycle, and the assertions do so. The register keeps bit 0 set and never holds the 10 pattern in bits 2:1. The two fault pulses never coincide. A fault cycle never changes the register. Any change to the register traces back to a privileged write with select index 0.

Other behaviour needs the stimulus the bench scenarios provide. This covers the priority order when several rules fail at once, the exact placement of the two halves, and the effect of the capability mask on bit 2 and on the upper bits. It also covers the permit outputs following live changes of `os_en`. The bench checks these against a reference model under random and directed attempts.

// File: rtl/xcr_guard_pkg.sv
package xcr_guard_pkg;

    parameter int unsigned REG_W  = 64;
    parameter int unsigned HALF_W = REG_W / 2;
    parameter int unsigned SEL_W  = 32;
    parameter int unsigned PRIV_W = 2;

    // Bit positions whose meaning other logic decodes
    parameter int unsigned BASE_BIT = 0;
    parameter int unsigned LANE_BIT = 1;
    parameter int unsigned VEC_BIT  = 2;
    parameter int unsigned BND_LO   = 3;
    parameter int unsigned BND_HI   = 4;

    localparam logic [REG_W-1:0] RESET_VAL       = REG_W'(1) << BASE_BIT;
    localparam logic [REG_W-1:0] ALWAYS_SETTABLE = (REG_W'(1) << BASE_BIT) | (REG_W'(1) << LANE_BIT);

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_UD   = 2'd1,
        FLT_GP   = 2'd2
    } fault_e;

    typedef struct packed {
        logic              os_en;
        logic [PRIV_W-1:0] priv;
        logic [SEL_W-1:0]  sel;
        logic [REG_W-1:0]  val;
        logic              wr;
        logic              rd;
    } attempt_t;

    typedef struct packed {
        fault_e           fault;
        logic             accept;
        logic [REG_W-1:0] val;
    } verdict_t;

    // True when the proposed value breaks any inter-bit or capability rule
    function automatic logic value_bad(input logic [REG_W-1:0] v, input logic [REG_W-1:0] cap);
        logic missing_base;
        logic vec_wo_lane;
        logic unsupported;
        missing_base = !v[BASE_BIT];
        vec_wo_lane  = v[VEC_BIT] && !v[LANE_BIT];
        unsupported  = |(v & ~(cap | ALWAYS_SETTABLE));
        return missing_base || vec_wo_lane || unsupported;
    endfunction

endpackage

// File: rtl/xcr_wr_judge.sv
module xcr_wr_judge
    import xcr_guard_pkg::*;
(
    input  attempt_t         att,
    input  logic [REG_W-1:0] cap,
    output verdict_t         vd
);
    always_comb begin
        vd.fault  = FLT_NONE;
        vd.accept = 1'b0;
        vd.val    = att.val;
        if (att.wr || att.rd) begin
            if (!att.os_en) begin
                vd.fault = FLT_UD;
            end else if (att.wr) begin
                if (att.priv != '0) begin
                    vd.fault = FLT_GP;
                end else if (att.sel != '0) begin
                    vd.fault = FLT_GP;
                end else if (value_bad(att.val, cap)) begin
                    vd.fault = FLT_GP;
                end else begin
                    vd.accept = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/xcr_reg_store.sv
module xcr_reg_store
    import xcr_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  verdict_t         vd,
    output logic [REG_W-1:0] q,
    output logic             ud,
    output logic             gp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q  <= RESET_VAL;
            ud <= 1'b0;
            gp <= 1'b0;
        end else begin
            if (vd.accept) begin
                q <= vd.val;
            end
            ud <= (vd.fault == FLT_UD);
            gp <= (vd.fault == FLT_GP);
        end
    end

    p_hold_on_fault_r1: assert property (@(posedge clk) disable iff (rst)
        (ud || gp) |-> (q == $past(q)));

    p_base_kept_r4: assert property (@(posedge clk) disable iff (rst)
        q[BASE_BIT]);

    p_no_vec_wo_lane_r5: assert property (@(posedge clk) disable iff (rst)
        !(q[VEC_BIT] && !q[LANE_BIT]));

    p_single_fault_r9: assert property (@(posedge clk) disable iff (rst)
        $countones({ud, gp}) <= 1);
endmodule

// File: rtl/xcr_permit_gen.sv
module xcr_permit_gen
    import xcr_guard_pkg::*;
(
    input  logic             os_en,
    input  logic [REG_W-1:0] q,
    output logic             vec_ok,
    output logic             bnd_ok
);
    always_comb begin
        vec_ok = os_en && q[VEC_BIT];
        bnd_ok = os_en && (&q[BND_HI:BND_LO]);
    end
endmodule

// File: rtl/ext_ctl_reg_guard.sv
module ext_ctl_reg_guard
    import xcr_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              os_en,
    input  logic [PRIV_W-1:0] priv_lvl,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [HALF_W-1:0] wr_lo,
    input  logic [HALF_W-1:0] wr_hi,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [REG_W-1:0]  cap_mask,
    output logic [REG_W-1:0]  ctl_q,
    output logic              ud_pulse,
    output logic              gp_pulse,
    output logic              vec_ok,
    output logic              bnd_ok
);
    attempt_t att;
    verdict_t vd;

    always_comb begin
        att.os_en = os_en;
        att.priv  = priv_lvl;
        att.sel   = wr_sel;
        att.val   = {wr_hi, wr_lo};
        att.wr    = wr_req;
        att.rd    = rd_req;
    end

    xcr_wr_judge u_judge (
        .att (att),
        .cap (cap_mask),
        .vd  (vd)
    );

    xcr_reg_store u_store (
        .clk (clk),
        .rst (rst),
        .vd  (vd),
        .q   (ctl_q),
        .ud  (ud_pulse),
        .gp  (gp_pulse)
    );

    xcr_permit_gen u_permit (
        .os_en  (os_en),
        .q      (ctl_q),
        .vec_ok (vec_ok),
        .bnd_ok (bnd_ok)
    );

    p_update_needs_grant_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctl_q) |-> $past(wr_req && os_en && (priv_lvl == '0) && (wr_sel == '0)));

    p_gp_from_write_r2: assert property (@(posedge clk) disable iff (rst)
        gp_pulse |-> $past(wr_req && os_en));

    p_ud_needs_os_off_r1: assert property (@(posedge clk) disable iff (rst)
        ud_pulse |-> $past(!os_en && (wr_req || rd_req)));
endmodule

// File: tb/test_ext_ctl_reg_guard.sv
module test_ext_ctl_reg_guard;

    logic        clk = 1'b0;
    logic        rst;
    logic        os_en;
    logic [1:0]  priv_lvl;
    logic [31:0] wr_sel;
    logic [31:0] wr_lo;
    logic [31:0] wr_hi;
    logic        wr_req;
    logic        rd_req;
    logic [63:0] cap_mask;
    logic [63:0] ctl_q;
    logic        ud_pulse;
    logic        gp_pulse;
    logic        vec_ok;
    logic        bnd_ok;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] m_q;

    always #4 clk = ~clk;

    ext_ctl_reg_guard i_ext_ctl_reg_guard (
        .clk(clk), .rst(rst), .os_en(os_en), .priv_lvl(priv_lvl),
        .wr_sel(wr_sel), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_req(wr_req),
        .rd_req(rd_req), .cap_mask(cap_mask), .ctl_q(ctl_q),
        .ud_pulse(ud_pulse), .gp_pulse(gp_pulse), .vec_ok(vec_ok), .bnd_ok(bnd_ok)
    );

    // Reference: returns 0 none, 1 invalid-opcode, 2 protection; tag names the rule
    function automatic int ref_fault(input logic os, input logic [1:0] pl, input logic [31:0] sel,
                                     input logic [63:0] v, input logic [63:0] cap,
                                     input logic wr, input logic rd, output string tag);
        tag = wr ? "R3" : "R10";
        if (!(wr || rd)) return 0;
        if (!os) begin tag = "R1"; return 1; end
        if (!wr) return 0;
        if (pl != 2'd0)                begin tag = "R2"; return 2; end
        if (sel != 32'd0)              begin tag = "R3"; return 2; end
        if (!v[0])                     begin tag = "R4"; return 2; end
        if (v[2:1] == 2'b10)           begin tag = "R5"; return 2; end
        if ((v & ~(cap | 64'h3)) != 0) begin tag = "R6"; return 2; end
        return 0;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag, input logic eud, input logic egp);
        chk(tag, ctl_q, m_q, "ctl_q");
        chk("R9", {63'd0, ud_pulse}, {63'd0, eud}, {tag, " ud_pulse"});
        chk("R9", {63'd0, gp_pulse}, {63'd0, egp}, {tag, " gp_pulse"});
        chk("R7", {63'd0, vec_ok}, {63'd0, os_en & m_q[2]}, "vec_ok");
        chk("R8", {63'd0, bnd_ok}, {63'd0, os_en & (&m_q[4:3])}, "bnd_ok");
    endtask

    // Called at a falling edge; returns at the falling edge after the result
    task automatic do_op(input logic os, input logic [1:0] pl, input logic [31:0] sel,
                         input logic [63:0] v, input logic wr, input logic rd);
        string tag;
        int f;
        os_en = os; priv_lvl = pl; wr_sel = sel; wr_hi = v[63:32]; wr_lo = v[31:0];
        wr_req = wr; rd_req = rd;
        f = ref_fault(os, pl, sel, v, cap_mask, wr, rd, tag);
        if (wr && f == 0) m_q = v;
        @(negedge clk);
        check_outputs(tag, f == 1, f == 2);
        wr_req = 1'b0; rd_req = 1'b0;
        @(negedge clk);
        check_outputs("R9", 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] v;
        process::self().srandom(32'd2024);
        void'($urandom(32'd2024));
        rst = 1'b1; os_en = 1'b1; priv_lvl = 2'd0; wr_sel = '0; wr_lo = '0; wr_hi = '0;
        wr_req = 1'b0; rd_req = 1'b0; cap_mask = 64'h1F;
        m_q = 64'h1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_outputs("R4", 1'b0, 1'b0); // reset value 1

        // Directed corners
        do_op(1'b1, 2'd0, 32'd0, 64'h7, 1'b1, 1'b0);            // R3 legal, vector permit
        do_op(1'b1, 2'd0, 32'd0, 64'h1F, 1'b1, 1'b0);           // R8 bounds permit
        do_op(1'b0, 2'd0, 32'd0, 64'h1F, 1'b0, 1'b0);           // R7/R8 os off idles low
        do_op(1'b0, 2'd0, 32'd0, 64'h3, 1'b1, 1'b0);            // R1 write with os off
        do_op(1'b0, 2'd0, 32'd0, 64'h3, 1'b0, 1'b1);            // R1 read with os off
        do_op(1'b0, 2'd3, 32'd5, 64'h0, 1'b1, 1'b0);            // R9 ud beats gp
        do_op(1'b1, 2'd3, 32'd0, 64'h3, 1'b1, 1'b0);            // R2
        do_op(1'b1, 2'd0, 32'd1, 64'h3, 1'b1, 1'b0);            // R3 nonzero select
        do_op(1'b1, 2'd0, 32'd0, 64'h6, 1'b1, 1'b0);            // R4 bit0 clear
        do_op(1'b1, 2'd0, 32'd0, 64'h5, 1'b1, 1'b0);            // R5 pattern 10
        do_op(1'b1, 2'd0, 32'd0, 64'h1, 1'b1, 1'b0);            // R3 back to base
        do_op(1'b1, 2'd0, 32'd0, 64'h1, 1'b0, 1'b1);            // R10 read
        cap_mask = 64'h0;
        do_op(1'b1, 2'd0, 32'd0, 64'h7, 1'b1, 1'b0);            // R6 bit2 unsupported
        do_op(1'b1, 2'd0, 32'd0, 64'h3, 1'b1, 1'b0);            // R6 bit1 always settable
        cap_mask = 64'hA5A5_0000_0000_0007;
        do_op(1'b1, 2'd0, 32'd0, 64'h8000_0000_0000_0003, 1'b1, 1'b0); // R3 high half
        do_op(1'b1, 2'd0, 32'd0, 64'h4000_0000_0000_0003, 1'b1, 1'b0); // R6 upper bit

        // Constrained random
        for (int i = 0; i < 3000; i++) begin
            logic       os;
            logic [1:0] pl;
            logic [31:0] sel;
            logic wr, rd;
            if (i % 100 == 0) cap_mask = {$urandom & $urandom, 27'd0, 5'($urandom)};
            os  = ($urandom % 8) != 0;
            pl  = ($urandom % 2) ? 2'd0 : 2'($urandom);
            sel = ($urandom % 8 == 0) ? $urandom : 32'd0;
            case ($urandom % 4)
                0: v = {$urandom, $urandom};
                1: v = {32'd0, 27'd0, 5'($urandom)};
                2: v = {32'd0, 27'd0, 5'($urandom)} | 64'h1;
                default: v = ({$urandom, $urandom} & (cap_mask | 64'h3)) | 64'h1;
            endcase
            wr = ($urandom % 4) != 0;
            rd = !wr && ($urandom % 2);
            do_op(os, pl, sel, v, wr, rd);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule